// File: doc/BRIEF.md
# Two-Level Priority Queue Arbiter

This block lets three requesters share one single-port resource, such as an on-chip memory, without their commands colliding. Each requester raises a request bit and keeps it high until it is served. The block records requesters in arrival order in one of two small circular queues. A per-requester class bit decides the queue: requesters in the urgent class go to the urgent queue and the rest go to the normal queue. The head of the urgent queue is served before anything in the normal queue.

The granted requester owns the resource for as long as its request stays high. It can therefore issue a read followed by a dependent write, such as a read-modify-write increment, without another requester cutting in. When the owner lowers its request, the grant is withdrawn and the requester leaves its queue. An urgent requester cannot take the resource twice in a row while a normal-class requester is waiting. While a grant is active, the block also steers the owner's address, write data and write flag onto the resource bus.

The control follows two named states. In FREE no grant is active. The "award" transition moves FREE to HELD when a queue head is eligible. In HELD one requester owns the bus. The "release" transition moves HELD back to FREE on the first clock edge at which the owner's request is low.

Top module: `pq_arbiter`

## Requirements
- R1: The grant vector never has more than one bit set. Bit i stands for requester i.
- R2: At each clock edge, at most one new requester is put in a queue. If several new requests are high at once, the lowest index goes first. Within a queue, grants follow arrival order. A grant appears at the earliest on the second clock edge at which the request is seen high.
- R3: A requester that is queued or owning is not queued again until it has been released, even if its request stays high.
- R4: A grant stays unchanged while the owner's request is high. It is cleared on the first edge at which that request is low, and the owner leaves its queue at the same edge.
- R5: A requester whose hi_pri bit is 1 at the edge where it is queued goes to the urgent queue. A non-empty urgent queue is served before the normal queue.
- R6: Suppose the last grant went to urgent requester X and X is again at the head of the urgent queue. If a normal-class requester is queued, X is skipped and the normal-class requester is served. If a normal-class requester is high but not yet queued, no grant is issued until it is queued. If nobody else is waiting, X may be granted again.
- R7: Queueing a new requester and releasing the owner can happen at the same edge, and both take effect.
- R8: A grant is awarded only at an edge where no grant is active and a queue is non-empty. After a release, the bus therefore stays idle for at least one cycle.
- R9: mem_en is high exactly when a grant is active. mem_addr, mem_wdata and mem_write carry the owner's slice: bits [i*AW +: AW] of req_addr, bits [i*DW +: DW] of req_wdata and bit i of req_write. Here mem_write = 1 means a write. With no grant, all four outputs are 0.
- R10: After reset, both queues are empty and no grant is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N (3) | Request bit per requester |
| hi_pri | input | N (3) | Urgent-class bit per requester, sampled when queued |
| req_addr | input | N*AW (24) | Packed requester addresses |
| req_wdata | input | N*DW (96) | Packed requester write data |
| req_write | input | N (3) | Write flag per requester (1 = write) |
| grant | output | N (3) | One-hot grant, zero when idle |
| mem_en | output | 1 | Resource enable |
| mem_addr | output | AW (8) | Owner's address |
| mem_wdata | output | DW (32) | Owner's write data |
| mem_write | output | 1 | Owner's write flag |

## Verification
The assertions assume that every requester holds its request high from the moment it raises it until it has been granted. They also assume that a released requester keeps its request low for at least one clock edge before raising it again. Without these two conditions, queue membership and ownership can no longer be reasoned about. The random stimulus models each requester as an idle, waiting or owning agent that follows these rules. Such an agent changes its class bit only while idle and holds ownership for a random number of cycles. Directed sequences cover simultaneous arrivals, a release at the same edge as a new arrival, urgent-before-normal service, and the repeat-grant block.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [0:0] {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } own_state_e;

    function automatic int id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pq_ring.sv
module pq_ring #(
    parameter int DEPTH = 4,
    parameter int IDW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic [IDW-1:0] head_id,
    output logic           empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDW-1:0] slot_q [DEPTH];
    logic [PW-1:0]  head_q;
    logic [PW-1:0]  tail_q;
    logic [PW-1:0]  occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + PW'(1);
            if (pop)  head_q <= head_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[tail_q] <= push_id;
    end

    assign head_id = slot_q[head_q];
    assign empty   = (head_q == tail_q);
    assign occ     = tail_q - head_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (int'(occ) < DEPTH - 1)); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R4

endmodule

// File: rtl/pq_sched.sv
module pq_sched
    import pq_pkg::*;
#(
    parameter int N     = 3,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] hi_pri,
    output logic [N-1:0] grant_o
);
    localparam int IDW = id_width(N);

    own_state_e     state_q, state_d;
    logic [N-1:0]   member_q;
    logic [IDW-1:0] own_q;
    logic           own_hi_q;
    logic [IDW-1:0] last_id_q;
    logic           last_hi_q;

    logic [N-1:0]   pend;
    logic           enq_v;
    logic [IDW-1:0] enq_id;
    logic           enq_hi;
    logic [N-1:0]   enq_mask;
    logic           lo_pend;

    logic           rel;
    logic [N-1:0]   rel_mask;
    logic           rep_block;
    logic           take;
    logic           take_hi;
    logic [IDW-1:0] pick;
    logic           award;

    logic [IDW-1:0] hi_head, lo_head;
    logic           hi_empty, lo_empty;

    // Arrival selection: lowest index among requests not yet queued.
    always_comb begin
        pend   = req & ~member_q;
        enq_v  = |pend;
        enq_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) enq_id = IDW'(i);
        end
        enq_hi   = hi_pri[enq_id];
        enq_mask = enq_v ? (N'(1) << enq_id) : '0;
        lo_pend  = |(pend & ~hi_pri);
    end

    pq_ring #(.DEPTH(DEPTH), .IDW(IDW)) u_hi_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (enq_v && enq_hi),
        .push_id (enq_id),
        .pop     (rel && own_hi_q),
        .head_id (hi_head),
        .empty   (hi_empty)
    );

    pq_ring #(.DEPTH(DEPTH), .IDW(IDW)) u_lo_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (enq_v && !enq_hi),
        .push_id (enq_id),
        .pop     (rel && !own_hi_q),
        .head_id (lo_head),
        .empty   (lo_empty)
    );

    // Selection of the next owner and next state.
    always_comb begin
        rel       = (state_q == ST_HELD) && !req[own_q];
        rel_mask  = rel ? (N'(1) << own_q) : '0;
        rep_block = last_hi_q && !hi_empty && (hi_head == last_id_q)
                    && (!lo_empty || lo_pend);
        take      = 1'b0;
        take_hi   = 1'b0;
        pick      = '0;
        if (!hi_empty && !rep_block) begin
            take    = 1'b1;
            take_hi = 1'b1;
            pick    = hi_head;
        end else if (!lo_empty) begin
            take    = 1'b1;
            pick    = lo_head;
        end
        state_d = state_q;
        award   = 1'b0;
        unique case (state_q)
            ST_FREE: if (take) begin
                state_d = ST_HELD;
                award   = 1'b1;
            end
            ST_HELD: if (rel) state_d = ST_FREE;
            default: state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            member_q  <= '0;
            own_q     <= '0;
            own_hi_q  <= 1'b0;
            last_id_q <= '0;
            last_hi_q <= 1'b0;
        end else begin
            member_q <= (member_q | enq_mask) & ~rel_mask;
            if (award) begin
                own_q     <= pick;
                own_hi_q  <= take_hi;
                last_id_q <= pick;
                last_hi_q <= take_hi;
            end
        end
    end

    assign grant_o = (state_q == ST_HELD) ? (N'(1) << own_q) : '0;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R1

    AST_OWNER_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> ((grant_o & member_q) == grant_o)); // R3

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & req) != '0) |=> (grant_o == $past(grant_o))); // R4

    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != '0) && ((grant_o & req) == '0)) |=> (grant_o == '0)); // R4

    AST_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |=> ((grant_o == '0) || (grant_o == $past(grant_o)))); // R8

endmodule

// File: rtl/pq_busmux.sv
module pq_busmux #(
    parameter int N  = 3,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic [N-1:0]    grant,
    input  logic [N*AW-1:0] req_addr,
    input  logic [N*DW-1:0] req_wdata,
    input  logic [N-1:0]    req_write,
    output logic            mem_en,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_write
);
    logic [AW-1:0] a_gated [N];
    logic [DW-1:0] d_gated [N];

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign a_gated[g] = req_addr[g*AW +: AW]  & {AW{grant[g]}};
        assign d_gated[g] = req_wdata[g*DW +: DW] & {DW{grant[g]}};
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        for (int i = 0; i < N; i++) begin
            mem_addr  = mem_addr  | a_gated[i];
            mem_wdata = mem_wdata | d_gated[i];
        end
        mem_write = |(req_write & grant);
        mem_en    = |grant;
    end

endmodule

// File: rtl/pq_arbiter.sv
module pq_arbiter #(
    parameter int N     = 3,
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N-1:0]    hi_pri,
    input  logic [N*AW-1:0] req_addr,
    input  logic [N*DW-1:0] req_wdata,
    input  logic [N-1:0]    req_write,
    output logic [N-1:0]    grant,
    output logic            mem_en,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_write
);

    pq_sched #(.N(N), .DEPTH(DEPTH)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .hi_pri  (hi_pri),
        .grant_o (grant)
    );

    pq_busmux #(.N(N), .AW(AW), .DW(DW)) u_mux (
        .grant     (grant),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .mem_en    (mem_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_write (mem_write)
    );

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> (mem_addr == '0 && mem_wdata == '0 && !mem_write)); // R9

    AST_EN_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> $onehot(grant)); // R9

endmodule

// File: tb/sim_pq_arbiter.sv
module sim_pq_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3, AW = 8, DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0, hi = '0, wr = '0;
    logic [N*AW-1:0] addr = '0;
    logic [N*DW-1:0] wdat = '0;
    logic [N-1:0] grant;
    logic mem_en, mem_write;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int errs = 0, checks = 0;
    bit done = 0;

    // reference model state
    bit [N-1:0] m_member;
    int hq[$], lq[$];
    bit m_held, m_own_hi, m_last_hi;
    int m_own, m_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    pq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .hi_pri(hi),
        .req_addr(addr), .req_wdata(wdat), .req_write(wr),
        .grant(grant), .mem_en(mem_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_write(mem_write)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_grant();
        return m_held ? (N'(1) << m_own) : '0;
    endfunction

    task automatic model_reset();
        m_member = '0; hq.delete(); lq.delete();
        m_held = 0; m_own = 0; m_own_hi = 0; m_last = 0; m_last_hi = 0;
    endtask

    task automatic model_edge();
        bit [N-1:0] pend;
        int eid;
        bit lo_pend, rel, block;
        pend = req & ~m_member;
        eid = -1;
        for (int i = N - 1; i >= 0; i--) if (pend[i]) eid = i;
        lo_pend = |(pend & ~hi);
        rel = m_held && !req[m_own];
        if (rel) begin
            if (m_own_hi) void'(hq.pop_front()); else void'(lq.pop_front());
            m_member[m_own] = 1'b0;
            m_held = 0;
        end else if (!m_held) begin
            block = m_last_hi && hq.size() > 0 && hq[0] == m_last && (lq.size() > 0 || lo_pend);
            if (hq.size() > 0 && !block) begin
                m_held = 1; m_own = hq[0]; m_own_hi = 1;
            end else if (lq.size() > 0) begin
                m_held = 1; m_own = lq[0]; m_own_hi = 0;
            end
            if (m_held) begin m_last = m_own; m_last_hi = m_own_hi; end
        end
        if (eid >= 0) begin
            if (hi[eid]) hq.push_back(eid); else lq.push_back(eid);
            m_member[eid] = 1'b1;
        end
    endtask

    task automatic tick(input string tag);
        logic [N-1:0] eg;
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        logic ew;
        @(posedge clk);
        model_edge();
        #1;
        eg = exp_grant();
        ea = '0; ed = '0; ew = 1'b0;
        for (int i = 0; i < N; i++) if (eg[i]) begin
            ea = addr[i*AW +: AW]; ed = wdat[i*DW +: DW]; ew = wr[i];
        end
        chk(grant == eg, tag, 32'(grant), 32'(eg));
        chk(mem_en == (eg != '0) && mem_addr == ea && mem_wdata == ed && mem_write == ew,
            "R9 bus", {mem_en, 7'(mem_write), 8'd0, mem_addr}, {(eg != '0), 7'(ew), 8'd0, ea});
    endtask

    task automatic cg(input logic [N-1:0] e, input string tag);
        chk(grant == e, tag, 32'(grant), 32'(e));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int st[N], hold[N];
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            addr[i*AW +: AW] = AW'(8'hA0 + i);
            wdat[i*DW +: DW] = 32'hD000_0000 + 32'(i);
        end
        wr = 3'b010;
        req = 3'b111;
        model_reset();
        repeat (2) @(posedge clk);
        #1;
        chk(grant == '0 && !mem_en, "R10 reset", {31'd0, mem_en} | 32'(grant), 0);
        rst_n = 1'b1;

        // A: simultaneous arrival, hold, release, overlap of enqueue and release
        tick("R10"); cg(3'b000, "R8 first edge queues only");
        tick("R2");  cg(3'b001, "R2 lowest index first");
        chk(mem_addr == 8'hA1 - 1 && mem_en, "R9 owner address", 32'(mem_addr), 32'hA0);
        repeat (3) begin tick("R4"); cg(3'b001, "R4 held"); end
        req[0] = 0; tick("R4"); cg(3'b000, "R4 dropped");
        tick("R2"); cg(3'b010, "R2 arrival order");
        chk(mem_write == 1'b1, "R9 write flag", 32'(mem_write), 1);
        req[0] = 1; req[1] = 0; tick("R7"); cg(3'b000, "R7 release with enqueue");
        tick("R2"); cg(3'b100, "R2 third");
        req[2] = 0; tick("R4"); tick("R7"); cg(3'b001, "R7 enqueue kept");
        req[0] = 0; tick("R4"); tick("R8"); cg(3'b000, "R8 idle");
        chk(mem_addr == 0 && mem_wdata == 0 && !mem_write, "R9 idle zero", 32'(mem_wdata), 0);

        // B: no duplicate queueing while owning
        req[1] = 1; tick("R3"); tick("R3"); cg(3'b010, "R3 grant");
        repeat (3) tick("R3");
        req[1] = 0; req[0] = 1; tick("R3"); cg(3'b000, "R3 release");
        tick("R3"); cg(3'b001, "R3 no stale entry");
        req[0] = 0; tick("R4"); tick("R8");

        // C: urgent queue first
        hi = 3'b100; req = 3'b111;
        tick("R5"); tick("R5"); cg(3'b001, "R5 only normal queued");
        req[0] = 0; tick("R5"); cg(3'b000, "R5 release");
        tick("R5"); cg(3'b100, "R5 urgent before normal");
        req[2] = 0; tick("R5"); tick("R5"); cg(3'b010, "R5 normal after");
        req[1] = 0; tick("R4"); tick("R8");

        // D: repeat-grant block
        hi = 3'b001; req = 3'b001;
        tick("R6"); tick("R6"); cg(3'b001, "R6 first grant");
        req[0] = 0; tick("R6"); cg(3'b000, "R6 release");
        req = 3'b101; tick("R6"); cg(3'b000, "R6 queues empty");
        tick("R6"); cg(3'b000, "R6 blocked while normal pending");
        tick("R6"); cg(3'b100, "R6 normal served");
        req[2] = 0; tick("R6"); tick("R6"); cg(3'b001, "R6 urgent after normal");
        req[0] = 0; tick("R6"); req[0] = 1; tick("R6");
        tick("R6"); cg(3'b001, "R6 repeat allowed alone");
        req[0] = 0; tick("R4"); tick("R8");

        // random agents
        for (int i = 0; i < N; i++) begin st[i] = 0; hold[i] = 0; end
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                case (st[i])
                    0: if ($urandom % 4 == 0) begin
                        hi[i] = 1'($urandom); req[i] = 1'b1; st[i] = 1;
                    end
                    1: if (grant[i]) begin hold[i] = int'($urandom % 5); st[i] = 2; end
                    default: if (hold[i] == 0) begin req[i] = 1'b0; st[i] = 0; end
                             else hold[i]--;
                endcase
                wdat[i*DW +: DW] = $urandom;
            end
            wr = 3'($urandom);
            tick("R5 R6 R2 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule